// File: doc/BRIEF.md
# Flash Page Buffer Loader

This block sits behind a serial command decoder and collects a flash page one byte at a time. Each load command names a word inside the page by a 7-bit offset and carries one data byte marked as either the low or the high half of that word. A write-page command hands the whole buffer to the array. The page address for that handoff is built from two parts: an upper byte held in a persistent extension register, and address bits 15:8 taken from the command. After each handoff the buffer returns to the erased pattern.

The block also accepts single-byte EEPROM writes and issues each one as an erase strobe followed by a write strobe. After a page commit or an EEPROM write, an internal timer keeps the block busy for a parameterized number of clocks. While the timer runs, every incoming command is dropped. A programmer can see the busy state by raising a poll input. A high byte that arrives for a word whose low byte was not loaded first is thrown away and sets a sticky order-error flag.

Top module: `page_loader`

## Requirements
- R1: A load-low command (op code 1) accepted with word offset `cmd_addr_i[6:0]` stores `cmd_data_i` as bits 7:0 of that buffer word.
- R2: A load-high command (op code 2) stores `cmd_data_i` as bits 15:8 of the word only when a load-low for the same word has been accepted since reset, since the last commit, or since the last accepted high byte for that word.
- R3: A load-high command that has no pending low byte for its word leaves the buffer unchanged and sets `err_order_o` one cycle later. The flag stays set until reset.
- R4: A set-extension command (op code 3) stores `cmd_data_i` as the upper page-address byte. The value holds across any number of commits until the next accepted set-extension command. It resets to 0x00.
- R5: A write-page command (op code 4) raises `commit_valid_o` for exactly one cycle, starting the cycle after it is accepted. During that pulse, `commit_addr_o` equals {extension byte, `cmd_addr_i[15:8]`} and `commit_data_o[16*i+15:16*i]` holds buffer word i.
- R6: At reset, and in the cycle after every commit pulse, all buffer words read 0xFFFF and no word has a pending low byte.
- R7: An EEPROM write (op code 5) pulses `ee_erase_o` with `ee_addr_o` = `cmd_addr_i[EE_AW-1:0]` in the cycle after acceptance. In the following cycle it pulses `ee_write_o` with `ee_data_o` = `cmd_data_i`, and the address is unchanged.
- R8: The block is busy for FLASH_WAIT cycles starting the cycle after a write-page is accepted. It is busy for EE_WAIT cycles starting the cycle after an EEPROM write is accepted.
- R9: Any command presented while the block is busy is ignored and changes no state.
- R10: `poll_busy_o` equals the busy state while `poll_i` is high and is 0 while `poll_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Op code: 1 load-low, 2 load-high, 3 set-extension, 4 write-page, 5 EEPROM write |
| cmd_addr_i | input | 16 | Command address |
| cmd_data_i | input | 8 | Command data byte |
| poll_i | input | 1 | Busy poll request |
| poll_busy_o | output | 1 | Busy state while polled |
| err_order_o | output | 1 | Sticky byte-order error |
| commit_valid_o | output | 1 | Page commit pulse |
| commit_addr_o | output | 16 | Page address bits 23:8 |
| commit_data_o | output | 16*PAGE_WORDS | Page contents, word i at bits 16*i+15:16*i |
| ee_erase_o | output | 1 | EEPROM erase strobe |
| ee_write_o | output | 1 | EEPROM write strobe |
| ee_addr_o | output | EE_AW | EEPROM byte address |
| ee_data_o | output | 8 | EEPROM data byte |

## Verification
The bench drives each command on a falling edge and holds it for one cycle. It samples results on the next falling edge, which is when every registered result is due: buffer writes, the order flag, the commit pulse with its address and data, and the erase strobe. The EEPROM write strobe is due one falling edge after that. For busy, the bench counts falling edges from the first post-accept sample until `poll_busy_o` drops and compares the count with FLASH_WAIT or EE_WAIT. Buffer contents are checked through the commit port, against a bench model that replays the same byte ordering.

// File: rtl/plb_pkg.sv
package plb_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_LOAD_LO = 3'd1,
    OP_LOAD_HI = 3'd2,
    OP_SET_EXT = 3'd3,
    OP_WR_PAGE = 3'd4,
    OP_EE_WR   = 3'd5
  } op_e;
endpackage

// File: rtl/plb_page_buf.sv
module plb_page_buf #(
  parameter int WORDS = 128,
  localparam int WAW  = $clog2(WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic                clr_i,
  input  logic [WAW-1:0]      waddr_i,
  input  logic [7:0]          data_i,
  output logic                ord_err_o,
  output logic [16*WORDS-1:0] page_o
);
  logic [7:0]       lo_q [WORDS];
  logic [7:0]       hi_q [WORDS];
  logic [WORDS-1:0] seen_q;

  assign ord_err_o = wr_hi_i && !seen_q[waddr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      for (int i = 0; i < WORDS; i++) begin
        lo_q[i] <= 8'hFF;
        hi_q[i] <= 8'hFF;
      end
    end else if (clr_i) begin
      seen_q <= '0;
      for (int i = 0; i < WORDS; i++) begin
        lo_q[i] <= 8'hFF;
        hi_q[i] <= 8'hFF;
      end
    end else if (wr_lo_i) begin
      lo_q[waddr_i]   <= data_i;
      seen_q[waddr_i] <= 1'b1;
    end else if (wr_hi_i && seen_q[waddr_i]) begin
      hi_q[waddr_i]   <= data_i;
      seen_q[waddr_i] <= 1'b0;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_flat
    assign page_o[16*g +: 16] = {hi_q[g], lo_q[g]};
  end
endmodule

// File: rtl/plb_busy_timer.sv
module plb_busy_timer #(
  parameter int FLASH_WAIT = 16,
  parameter int EE_WAIT    = 8,
  localparam int MAXW      = (FLASH_WAIT > EE_WAIT) ? FLASH_WAIT : EE_WAIT,
  localparam int CW        = $clog2(MAXW + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_flash_i,
  input  logic start_ee_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_flash_i) cnt_q <= CW'(FLASH_WAIT);
    else if (start_ee_i)    cnt_q <= CW'(EE_WAIT);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/plb_ee_seq.sv
module plb_ee_seq #(
  parameter int EE_AW = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [EE_AW-1:0] addr_i,
  input  logic [7:0]       data_i,
  output logic             erase_o,
  output logic             write_o,
  output logic [EE_AW-1:0] addr_o,
  output logic [7:0]       data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      erase_o <= 1'b0;
      write_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      erase_o <= start_i;
      write_o <= erase_o;
      if (start_i) begin
        addr_o <= addr_i;
        data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/page_loader.sv
module page_loader
  import plb_pkg::*;
#(
  parameter int PAGE_WORDS = 128,
  parameter int EE_AW      = 12,
  parameter int FLASH_WAIT = 16,
  parameter int EE_WAIT    = 8,
  localparam int WAW       = $clog2(PAGE_WORDS),
  localparam int PAGE_BITS = 16 * PAGE_WORDS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  input  logic [2:0]           cmd_op_i,
  input  logic [15:0]          cmd_addr_i,
  input  logic [7:0]           cmd_data_i,
  input  logic                 poll_i,
  output logic                 poll_busy_o,
  output logic                 err_order_o,
  output logic                 commit_valid_o,
  output logic [15:0]          commit_addr_o,
  output logic [PAGE_BITS-1:0] commit_data_o,
  output logic                 ee_erase_o,
  output logic                 ee_write_o,
  output logic [EE_AW-1:0]     ee_addr_o,
  output logic [7:0]           ee_data_o
);
  logic busy, acc, ord_err;
  logic do_lo, do_hi, do_ext, do_page, do_ee;
  logic [7:0] ext_q;

  assign acc     = cmd_valid_i && !busy;
  assign do_lo   = acc && (cmd_op_i == OP_LOAD_LO);
  assign do_hi   = acc && (cmd_op_i == OP_LOAD_HI);
  assign do_ext  = acc && (cmd_op_i == OP_SET_EXT);
  assign do_page = acc && (cmd_op_i == OP_WR_PAGE);
  assign do_ee   = acc && (cmd_op_i == OP_EE_WR);

  plb_page_buf #(.WORDS(PAGE_WORDS)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_lo_i   (do_lo),
    .wr_hi_i   (do_hi),
    .clr_i     (commit_valid_o),
    .waddr_i   (cmd_addr_i[WAW-1:0]),
    .data_i    (cmd_data_i),
    .ord_err_o (ord_err),
    .page_o    (commit_data_o)
  );

  plb_busy_timer #(.FLASH_WAIT(FLASH_WAIT), .EE_WAIT(EE_WAIT)) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_flash_i (do_page),
    .start_ee_i    (do_ee),
    .busy_o        (busy)
  );

  plb_ee_seq #(.EE_AW(EE_AW)) u_ee (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (do_ee),
    .addr_i  (cmd_addr_i[EE_AW-1:0]),
    .data_i  (cmd_data_i),
    .erase_o (ee_erase_o),
    .write_o (ee_write_o),
    .addr_o  (ee_addr_o),
    .data_o  (ee_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q          <= '0;
      err_order_o    <= 1'b0;
      commit_valid_o <= 1'b0;
      commit_addr_o  <= '0;
    end else begin
      if (do_ext) ext_q <= cmd_data_i;
      if (ord_err) err_order_o <= 1'b1;
      commit_valid_o <= do_page;
      if (do_page) commit_addr_o <= {ext_q, cmd_addr_i[15:8]};
    end
  end

  assign poll_busy_o = poll_i && busy;
endmodule

// File: rtl/plb_checker.sv
module plb_checker
  import plb_pkg::*;
#(
  parameter int PAGE_BITS = 2048
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cmd_valid_i,
  input logic [2:0]           cmd_op_i,
  input logic                 poll_i,
  input logic                 poll_busy_o,
  input logic                 err_order_o,
  input logic                 commit_valid_o,
  input logic [PAGE_BITS-1:0] commit_data_o,
  input logic                 ee_erase_o,
  input logic                 ee_write_o,
  input logic [11:0]          ee_addr_lo,
  input logic                 busy,
  input logic [7:0]           ext_q
);
  p_err_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_order_o |=> err_order_o);

  p_ext_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && cmd_op_i == OP_SET_EXT) |=> $stable(ext_q));

  p_commit_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_valid_o |=> !commit_valid_o);

  p_buf_cleared_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_valid_o |=> (commit_data_o == '1));

  p_erase_then_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_erase_o |=> (ee_write_o && $stable(ee_addr_lo)));

  p_busy_on_commit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_valid_o |-> busy);

  p_drop_when_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cmd_valid_i && cmd_op_i == OP_SET_EXT) |=> $stable(ext_q));

  p_poll_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !poll_i |-> !poll_busy_o);
endmodule

bind page_loader plb_checker #(.PAGE_BITS(PAGE_BITS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmd_valid_i    (cmd_valid_i),
  .cmd_op_i       (cmd_op_i),
  .poll_i         (poll_i),
  .poll_busy_o    (poll_busy_o),
  .err_order_o    (err_order_o),
  .commit_valid_o (commit_valid_o),
  .commit_data_o  (commit_data_o),
  .ee_erase_o     (ee_erase_o),
  .ee_write_o     (ee_write_o),
  .ee_addr_lo     (12'(ee_addr_o)),
  .busy           (busy),
  .ext_q          (ext_q)
);

// File: tb/page_loader_bench.sv
module page_loader_bench;
  import plb_pkg::*;
  localparam int PW = 128;
  localparam int EAW = 12;
  localparam int FW = 8;
  localparam int EW = 4;
  localparam int PB = 16 * PW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [15:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic poll = 1'b1;
  logic poll_busy, err_order, commit_valid, ee_erase, ee_write;
  logic [15:0] commit_addr;
  logic [PB-1:0] commit_data;
  logic [EAW-1:0] ee_addr;
  logic [7:0] ee_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] m_lo [PW];
  logic [7:0] m_hi [PW];
  bit m_seen [PW];
  logic [7:0] m_ext;
  bit m_err;

  always #4 clk = ~clk;

  page_loader #(.PAGE_WORDS(PW), .EE_AW(EAW), .FLASH_WAIT(FW), .EE_WAIT(EW)) u_page_loader (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .poll_i(poll),
    .poll_busy_o(poll_busy), .err_order_o(err_order), .commit_valid_o(commit_valid),
    .commit_addr_o(commit_addr), .commit_data_o(commit_data), .ee_erase_o(ee_erase),
    .ee_write_o(ee_write), .ee_addr_o(ee_addr), .ee_data_o(ee_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int i = 0; i < PW; i++) begin
      m_lo[i] = 8'hFF; m_hi[i] = 8'hFF; m_seen[i] = 1'b0;
    end
  endfunction

  function automatic logic [PB-1:0] exp_page();
    logic [PB-1:0] e;
    for (int i = 0; i < PW; i++) e[16*i +: 16] = {m_hi[i], m_lo[i]};
    return e;
  endfunction

  function automatic void model_apply(input logic [2:0] op, input logic [15:0] a, input logic [7:0] d);
    int w;
    w = int'(a[6:0]);
    case (op)
      3'd1: begin m_lo[w] = d; m_seen[w] = 1'b1; end
      3'd2: if (m_seen[w]) begin m_hi[w] = d; m_seen[w] = 1'b0; end else m_err = 1'b1;
      3'd3: m_ext = d;
      default: ;
    endcase
  endfunction

  // drive on a falling edge, return on the next falling edge
  task automatic send(input logic [2:0] op, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    poll = 1'b1;
    while (poll_busy) @(negedge clk);
  endtask

  // issue write-page, check pulse and data, count busy cycles
  task automatic commit_check(input logic [15:0] a, input string tag);
    logic [PB-1:0] e;
    int n;
    e = exp_page();
    poll = 1'b1;
    send(3'd4, a, 8'h00);
    chk(commit_valid === 1'b1, {tag, " R5 pulse"}, 64'(commit_valid), 64'd1);
    chk(commit_addr === {m_ext, a[15:8]}, {tag, " R5 addr"}, 64'(commit_addr), 64'({m_ext, a[15:8]}));
    chk(commit_data === e, {tag, " R1 R2 R5 data"}, commit_data[63:0], e[63:0]);
    n = 0;
    while (poll_busy) begin
      n++;
      @(negedge clk);
      if (n == 1) begin
        chk(commit_valid === 1'b0, {tag, " R5 single"}, 64'(commit_valid), 64'd0);
        chk(commit_data === '1, {tag, " R6 cleared"}, commit_data[63:0], 64'hFFFF_FFFF_FFFF_FFFF);
      end
    end
    chk(n == FW, {tag, " R8 flash busy"}, 64'(n), 64'(FW));
    model_clear();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] op;
    logic [15:0] a;
    logic [7:0] d;
    int n;
    void'($urandom(32'd1234));
    model_clear();
    m_ext = 8'h00; m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(err_order === 1'b0, "R3 reset", 64'(err_order), 64'd0);
    chk(poll_busy === 1'b0, "R10 reset", 64'(poll_busy), 64'd0);
    chk(commit_valid === 1'b0 && commit_data === '1, "R6 reset", commit_data[63:0], 64'hFFFF_FFFF_FFFF_FFFF);
    chk(ee_erase === 1'b0 && ee_write === 1'b0, "R7 reset", 64'({ee_erase, ee_write}), 64'd0);

    // R1 R2 directed; R3 high without low
    send(3'd1, 16'h0005, 8'h34); model_apply(3'd1, 16'h0005, 8'h34);
    send(3'd2, 16'h0005, 8'h12); model_apply(3'd2, 16'h0005, 8'h12);
    send(3'd2, 16'h0009, 8'hAA); model_apply(3'd2, 16'h0009, 8'hAA);
    chk(err_order === 1'b1, "R3 order flag", 64'(err_order), 64'd1);
    send(3'd2, 16'h0005, 8'h55); model_apply(3'd2, 16'h0005, 8'h55);
    send(3'd1, 16'h007F, 8'hC3); model_apply(3'd1, 16'h007F, 8'hC3);
    commit_check(16'hAB00, "dir1");
    chk(err_order === 1'b1, "R3 sticky", 64'(err_order), 64'd1);

    // R4 extension persists over two commits
    send(3'd3, 16'h0000, 8'h5C); model_apply(3'd3, 16'h0000, 8'h5C);
    send(3'd1, 16'h0000, 8'h01); model_apply(3'd1, 16'h0000, 8'h01);
    commit_check(16'h1200, "R4 first");
    commit_check(16'h1300, "R4 second");

    // R9 commands during busy are dropped; R10 poll gate
    send(3'd4, 16'h2000, 8'h00);
    model_clear();
    poll = 1'b0;
    send(3'd1, 16'h0003, 8'h99);
    chk(poll_busy === 1'b0, "R10 gated", 64'(poll_busy), 64'd0);
    poll = 1'b1;
    #1;
    chk(poll_busy === 1'b1, "R10 polled", 64'(poll_busy), 64'd1);
    send(3'd3, 16'h0000, 8'hEE);
    wait_idle();
    commit_check(16'h2100, "R9 dropped");

    // R7 EEPROM erase then write; R8 EE busy
    send(3'd5, 16'hF3A5, 8'h7E);
    chk(ee_erase === 1'b1 && ee_write === 1'b0, "R7 erase", 64'({ee_erase, ee_write}), 64'b10);
    chk(ee_addr === 12'h3A5, "R7 addr", 64'(ee_addr), 64'h3A5);
    n = 0;
    while (poll_busy) begin
      n++;
      @(negedge clk);
      if (n == 1) begin
        chk(ee_write === 1'b1 && ee_erase === 1'b0, "R7 write", 64'({ee_erase, ee_write}), 64'b01);
        chk(ee_data === 8'h7E && ee_addr === 12'h3A5, "R7 data", 64'({ee_addr, ee_data}), 64'h3A57E);
      end
    end
    chk(n == EW, "R8 ee busy", 64'(n), 64'(EW));

    // random rounds
    for (int r = 0; r < 20; r++) begin
      for (int k = 0; k < 30; k++) begin
        op = 3'($urandom_range(1, 3));
        a = 16'($urandom);
        if (r % 2 == 0) a[6:0] = 7'($urandom_range(0, 7));
        d = 8'($urandom);
        send(op, a, d);
        model_apply(op, a, d);
      end
      chk(err_order === m_err, "R3 random flag", 64'(err_order), 64'(m_err));
      commit_check(16'($urandom), "random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule